// File: doc/BRIEF.md
# Accelerated Layout Clock Follower

This block keeps a local copy of an accelerated layout time: minutes, hours and a running day count. The time advances at a programmable multiple of real time. A host-side parser supplies synchronisation events. Each event carries a rate multiplier, encoded minutes and hours, a day count and a flag that marks the data as valid. When the flag is set, the event loads the local time and the rate. Between events the block advances on its own, driven by a single-cycle real-time tick. It does not depend on repeated reads.

Minutes and hours travel in encoded form, as the two's-complement negation of the value in 8 bits (256 minus the value). The block decodes them on load and presents the time both encoded and plain. It raises a one-cycle pulse whenever a fast minute elapses. Every sync event restarts the sub-minute phase. It also restarts a real-time interval counter, which emits a resynchronisation request pulse when no sync event has arrived for a configurable number of ticks.

Top module: `fast_clock_follower`

## Requirements
- R1: After reset, minutes, hours, days, rate and both encoded outputs are 0, and neither the minute pulse nor the request pulse is asserted.
- R2: A sync event with the valid flag at 1 loads minutes as ((256 − enc) mod 256) mod 60. The encoded minute output always equals (256 − minutes) mod 256.
- R3: A valid sync event loads hours as ((256 − enc) mod 256) mod 24. The encoded hour output always equals (256 − hours) mod 256.
- R4: A valid sync event loads the day count and the 7-bit rate unchanged.
- R5: A sync event with the valid flag at 0 leaves minutes, hours, days and rate unchanged.
- R6: Each tick adds the rate to a phase accumulator. When the sum reaches 60 × TICKS_PER_SEC, one fast minute elapses and the sum minus that threshold is kept. The minute pulse is high for the one cycle after the tick's cycle, at the same time the advanced time appears.
- R7: While the rate is 0, ticks produce no minute pulse and the time outputs hold their values.
- R8: A minute advance from 59 gives 0 and increments the hours. An hour advance from 23 gives 0 and increments the days, all on the same edge. Days count upward modulo 2^DAY_W.
- R9: Any sync event, valid or not, clears the phase accumulator. A tick in the same cycle as a sync event is discarded.
- R10: The request pulse is high for one cycle after every PING_TICKS-th tick counted since the last sync event or the last request. A sync event restarts this count.
- R11: The time outputs change only on a cycle that shows the minute pulse, or on the cycle after a valid sync event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rt_tick | input | 1 | One-cycle real-time tick, TICKS_PER_SEC per second |
| sync_stb | input | 1 | Sync event strobe |
| sync_ok | input | 1 | Valid flag of the sync event |
| sync_rate | input | 7 | Rate multiplier, 0 freezes |
| sync_min_enc | input | 8 | Encoded minutes (256 − value) |
| sync_hr_enc | input | 8 | Encoded hours (256 − value) |
| sync_days | input | DAY_W | Day count |
| min_o | output | 6 | Current minutes, 0..59 |
| hr_o | output | 5 | Current hours, 0..23 |
| day_o | output | DAY_W | Current day count |
| min_enc_o | output | 8 | Encoded minutes |
| hr_enc_o | output | 8 | Encoded hours |
| rate_o | output | 7 | Rate in use |
| min_pulse_o | output | 1 | One-cycle pulse per fast minute |
| ping_o | output | 1 | One-cycle resynchronisation request |

## Verification
The assertions check on every cycle that the following invariants hold:
- minutes and hours stay in range;
- the phase stays below its threshold;
- no minute pulse appears while the rate is zero or right after a sync event;
- the hour carry follows a minute wrap;
- the time never moves without a pulse or a valid load;
- a sync event is never followed directly by a request.

The bench scenarios show the exact decode of all 256 encodings, the remainder arithmetic that sets when each minute falls at several rates, and the day wrap. They also show that an invalid sync still restarts the phase, and that a sync event cancels a request that was one tick away.

// File: rtl/fcf_pkg.sv
package fcf_pkg;
  localparam int RATE_W = 7;
  localparam int ENC_W  = 8;
  localparam int MIN_W  = 6;
  localparam int HR_W   = 5;
  localparam int MINS_PER_HR = 60;
  localparam int HRS_PER_DAY = 24;

  function automatic logic [MIN_W-1:0] dec_min(input logic [ENC_W-1:0] e);
    logic [ENC_W-1:0] v;
    v = ENC_W'(0) - e;
    return MIN_W'(v % ENC_W'(MINS_PER_HR));
  endfunction

  function automatic logic [HR_W-1:0] dec_hr(input logic [ENC_W-1:0] e);
    logic [ENC_W-1:0] v;
    v = ENC_W'(0) - e;
    return HR_W'(v % ENC_W'(HRS_PER_DAY));
  endfunction
endpackage

// File: rtl/fcf_phase.sv
module fcf_phase
  import fcf_pkg::*;
#(
  parameter int TH   = 600,
  parameter int PH_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              sync_stb,
  input  logic              sync_ok,
  input  logic [RATE_W-1:0] sync_rate,
  output logic [RATE_W-1:0] rate_q,
  output logic [PH_W-1:0]   phase_q,
  output logic              adv
);
  logic [PH_W-1:0] sum;

  always_comb begin
    sum = phase_q + PH_W'(rate_q);
    adv = tick && !sync_stb && (rate_q != '0) && (sum >= PH_W'(TH));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q  <= '0;
      phase_q <= '0;
    end else if (sync_stb) begin
      phase_q <= '0;
      if (sync_ok) rate_q <= sync_rate;
    end else if (tick) begin
      phase_q <= adv ? (sum - PH_W'(TH)) : sum;
    end
  end
endmodule

// File: rtl/fcf_tod.sv
module fcf_tod
  import fcf_pkg::*;
#(
  parameter int DAY_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             adv,
  input  logic [MIN_W-1:0] ld_min,
  input  logic [HR_W-1:0]  ld_hr,
  input  logic [DAY_W-1:0] ld_day,
  output logic [MIN_W-1:0] min_q,
  output logic [HR_W-1:0]  hr_q,
  output logic [DAY_W-1:0] day_q
);
  localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(MINS_PER_HR - 1);
  localparam logic [HR_W-1:0]  HR_LAST  = HR_W'(HRS_PER_DAY - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      min_q <= '0;
      hr_q  <= '0;
      day_q <= '0;
    end else if (load) begin
      min_q <= ld_min;
      hr_q  <= ld_hr;
      day_q <= ld_day;
    end else if (adv) begin
      if (min_q == MIN_LAST) begin
        min_q <= '0;
        if (hr_q == HR_LAST) begin
          hr_q  <= '0;
          day_q <= day_q + 1'b1;
        end else begin
          hr_q <= hr_q + 1'b1;
        end
      end else begin
        min_q <= min_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fcf_ping.sv
module fcf_ping #(
  parameter int PING_TICKS = 1200,
  parameter int CNT_W      = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic sync_stb,
  output logic ping_q
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      ping_q <= 1'b0;
    end else begin
      ping_q <= 1'b0;
      if (sync_stb) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt == CNT_W'(PING_TICKS - 1)) begin
          cnt    <= '0;
          ping_q <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fast_clock_follower.sv
module fast_clock_follower
  import fcf_pkg::*;
#(
  parameter int TICKS_PER_SEC = 10,
  parameter int DAY_W         = 7,
  parameter int PING_TICKS    = 1200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rt_tick,
  input  logic              sync_stb,
  input  logic              sync_ok,
  input  logic [RATE_W-1:0] sync_rate,
  input  logic [ENC_W-1:0]  sync_min_enc,
  input  logic [ENC_W-1:0]  sync_hr_enc,
  input  logic [DAY_W-1:0]  sync_days,
  output logic [MIN_W-1:0]  min_o,
  output logic [HR_W-1:0]   hr_o,
  output logic [DAY_W-1:0]  day_o,
  output logic [ENC_W-1:0]  min_enc_o,
  output logic [ENC_W-1:0]  hr_enc_o,
  output logic [RATE_W-1:0] rate_o,
  output logic              min_pulse_o,
  output logic              ping_o
);
  localparam int TH    = 60 * TICKS_PER_SEC;
  localparam int PH_W  = $clog2(TH + (1 << RATE_W));
  localparam int CNT_W = $clog2(PING_TICKS + 1);

  logic            adv;
  logic            load;
  logic [PH_W-1:0] phase_w;

  assign load = sync_stb && sync_ok;

  fcf_phase #(.TH(TH), .PH_W(PH_W)) u_phase (
    .clk(clk), .rst(rst), .tick(rt_tick), .sync_stb(sync_stb),
    .sync_ok(sync_ok), .sync_rate(sync_rate), .rate_q(rate_o),
    .phase_q(phase_w), .adv(adv)
  );

  fcf_tod #(.DAY_W(DAY_W)) u_tod (
    .clk(clk), .rst(rst), .load(load), .adv(adv),
    .ld_min(dec_min(sync_min_enc)), .ld_hr(dec_hr(sync_hr_enc)),
    .ld_day(sync_days), .min_q(min_o), .hr_q(hr_o), .day_q(day_o)
  );

  fcf_ping #(.PING_TICKS(PING_TICKS), .CNT_W(CNT_W)) u_ping (
    .clk(clk), .rst(rst), .tick(rt_tick), .sync_stb(sync_stb), .ping_q(ping_o)
  );

  always_ff @(posedge clk) begin
    if (rst) min_pulse_o <= 1'b0;
    else     min_pulse_o <= adv;
  end

  assign min_enc_o = ENC_W'(0) - ENC_W'(min_o);
  assign hr_enc_o  = ENC_W'(0) - ENC_W'(hr_o);
endmodule

// File: rtl/fcf_checks.sv
module fcf_checks #(
  parameter int TH    = 600,
  parameter int PH_W  = 10,
  parameter int DAY_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             sync_stb,
  input logic             sync_ok,
  input logic [5:0]       min_o,
  input logic [4:0]       hr_o,
  input logic [DAY_W-1:0] day_o,
  input logic [6:0]       rate_o,
  input logic [PH_W-1:0]  phase_w,
  input logic             min_pulse_o,
  input logic             ping_o
);
  assert_min_range_R2: assert property (@(posedge clk) disable iff (rst)
    min_o < 6'd60);

  assert_hr_range_R3: assert property (@(posedge clk) disable iff (rst)
    hr_o < 5'd24);

  assert_phase_below_R6: assert property (@(posedge clk) disable iff (rst)
    phase_w < PH_W'(TH));

  assert_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    min_pulse_o |-> ($past(rate_o) != 7'd0));

  assert_carry_R8: assert property (@(posedge clk) disable iff (rst)
    (min_pulse_o && min_o == 6'd0) |->
      (hr_o == (($past(hr_o) == 5'd23) ? 5'd0 : $past(hr_o) + 5'd1)));

  assert_sync_prio_R9: assert property (@(posedge clk) disable iff (rst)
    $past(sync_stb) |-> !min_pulse_o);

  assert_ping_restart_R10: assert property (@(posedge clk) disable iff (rst)
    $past(sync_stb) |-> !ping_o);

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!min_pulse_o && !$past(sync_stb && sync_ok)) |->
      ($stable(min_o) && $stable(hr_o) && $stable(day_o)));
endmodule

bind fast_clock_follower fcf_checks #(.TH(TH), .PH_W(PH_W), .DAY_W(DAY_W)) u_chk (
  .clk(clk), .rst(rst), .sync_stb(sync_stb), .sync_ok(sync_ok),
  .min_o(min_o), .hr_o(hr_o), .day_o(day_o), .rate_o(rate_o),
  .phase_w(phase_w), .min_pulse_o(min_pulse_o), .ping_o(ping_o)
);

// File: tb/fast_clock_follower_tb.sv
`timescale 1ns/1ps
module fast_clock_follower_tb;
  localparam int TPS   = 3;
  localparam int TH    = 60 * TPS;
  localparam int DAY_W = 4;
  localparam int PING  = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rt_tick = 1'b0, sync_stb = 1'b0, sync_ok = 1'b0;
  logic [6:0] sync_rate = '0;
  logic [7:0] sync_min_enc = '0, sync_hr_enc = '0;
  logic [DAY_W-1:0] sync_days = '0;
  logic [5:0] min_o;
  logic [4:0] hr_o;
  logic [DAY_W-1:0] day_o;
  logic [7:0] min_enc_o, hr_enc_o;
  logic [6:0] rate_o;
  logic min_pulse_o, ping_o;

  int checks = 0, failures = 0;
  int m_min = 0, m_hr = 0, m_day = 0, m_rate = 0, m_ph = 0, m_pc = 0;
  int e_pulse = 0, e_ping = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fast_clock_follower #(.TICKS_PER_SEC(TPS), .DAY_W(DAY_W), .PING_TICKS(PING)) u_dut (
    .clk(clk), .rst(rst), .rt_tick(rt_tick), .sync_stb(sync_stb), .sync_ok(sync_ok),
    .sync_rate(sync_rate), .sync_min_enc(sync_min_enc), .sync_hr_enc(sync_hr_enc),
    .sync_days(sync_days), .min_o(min_o), .hr_o(hr_o), .day_o(day_o),
    .min_enc_o(min_enc_o), .hr_enc_o(hr_enc_o), .rate_o(rate_o),
    .min_pulse_o(min_pulse_o), .ping_o(ping_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk({req, "/R2"}, "min", int'(min_o), m_min);
    chk({req, "/R2"}, "min_enc", int'(min_enc_o), (256 - m_min) % 256);
    chk({req, "/R3"}, "hr", int'(hr_o), m_hr);
    chk({req, "/R3"}, "hr_enc", int'(hr_enc_o), (256 - m_hr) % 256);
    chk({req, "/R4"}, "day", int'(day_o), m_day);
    chk({req, "/R5"}, "rate", int'(rate_o), m_rate);
    chk({req, "/R6"}, "pulse", int'(min_pulse_o), e_pulse);
    chk({req, "/R10"}, "ping", int'(ping_o), e_ping);
  endtask

  // Model of one real-time tick (R6, R7, R8, R10).
  task automatic model_tick();
    int s;
    e_pulse = 0;
    e_ping  = 0;
    if (m_pc == PING - 1) begin m_pc = 0; e_ping = 1; end
    else m_pc++;
    s = m_ph + m_rate;
    if (m_rate != 0 && s >= TH) begin
      m_ph = s - TH;
      e_pulse = 1;
      if (m_min == 59) begin
        m_min = 0;
        if (m_hr == 23) begin m_hr = 0; m_day = (m_day + 1) % (1 << DAY_W); end
        else m_hr++;
      end else m_min++;
    end else begin
      m_ph = s;
    end
  endtask

  task automatic do_tick(input string req);
    rt_tick = 1'b1;
    @(negedge clk);
    rt_tick = 1'b0;
    model_tick();
    check_all(req);
  endtask

  task automatic do_sync(input string req, input bit ok, input int rate,
                         input int menc, input int henc, input int days, input bit with_tick);
    sync_stb = 1'b1; sync_ok = ok; sync_rate = 7'(rate);
    sync_min_enc = 8'(menc); sync_hr_enc = 8'(henc); sync_days = DAY_W'(days);
    rt_tick = with_tick;
    @(negedge clk);
    sync_stb = 1'b0; sync_ok = 1'b0; rt_tick = 1'b0;
    m_ph = 0; m_pc = 0; e_pulse = 0; e_ping = 0;   // R9: phase cleared, tick dropped
    if (ok) begin
      m_rate = rate;
      m_min = ((256 - menc) % 256) % 60;
      m_hr  = ((256 - henc) % 256) % 24;
      m_day = days % (1 << DAY_W);
    end
    check_all(req);
  endtask

  task automatic idle(input string req);
    @(negedge clk);
    e_pulse = 0; e_ping = 0;
    check_all(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_all("R1 reset");

    // R7: frozen after reset, ticks do nothing
    for (int i = 0; i < 12; i++) do_tick("R7 reset-frozen");

    // R2 R3 R4: sweep every encoding
    for (int e = 0; e < 256; e++) do_sync("R2 R3 R4 decode", 1'b1, e % 128, e, 255 - e, e, 1'b0);

    // R5: invalid sync leaves time and rate alone, R9: still clears phase
    do_sync("R5 load", 1'b1, 100, 256 - 10, 256 - 5, 3, 1'b0);
    do_tick("R9 pre");                         // phase 100
    do_sync("R5 invalid", 1'b0, 7, 256 - 40, 256 - 20, 9, 1'b0);
    do_tick("R9 after-invalid");               // phase 100, no minute
    do_tick("R9 second");                      // 200 -> minute

    // R9: sync and tick together, tick discarded
    do_sync("R9 prio", 1'b1, 127, 256 - 1, 256 - 1, 1, 1'b1);
    idle("R11 idle");

    // R6 R7 R8: rate sweep from 23:58 on the last day
    foreach (int_rates[k]) begin
      do_sync("R8 preload", 1'b1, int_rates[k], 256 - 58, 256 - 23, (1 << DAY_W) - 1, 1'b0);
      for (int t = 0; t < 300; t++) do_tick("R6 R8 run");
      idle("R11 hold");
    end

    // R10: sync one tick before a request cancels it
    do_sync("R10 start", 1'b1, 1, 0, 0, 0, 1'b0);
    for (int t = 0; t < PING - 1; t++) do_tick("R10 count");
    do_sync("R10 cancel", 1'b1, 1, 0, 0, 0, 1'b0);
    for (int t = 0; t < 2 * PING + 1; t++) do_tick("R10 restart");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  int int_rates [6] = '{0, 1, 3, 59, 60, 127};
endmodule